// File: doc/BRIEF.md
# Configurable Two-Level Lookahead Adder

This block is a purely combinational adder of `DATA_W` bits. It takes two operands and a carry input, and it returns the sum together with the carry that leaves the top bit. The operand is cut into equal slices of `GROUP_W` bits. Each slice is handled by a group unit that holds its own slice adder. The group unit also reports two summary terms for the slice. The first is a group propagate, the AND of the per-bit propagates. The second is a group generate, which is the carry the slice would emit with its carry input forced low. A second-level carry network turns these summary terms and the external carry input into the carry entering every slice, and into the final carry-out.

Two build-time choices are independent of each other. The first is whether each slice adder forms its internal carries with flat lookahead or with a ripple chain. The second is whether the second-level network uses flat lookahead or ripples from slice to slice. All four combinations compute the same arithmetic result and differ only in gate depth and gate count. In a flat lookahead stage, every carry is built directly from the propagate and generate terms. No carry in such a stage is built from the carry below it. The per-bit propagate is the inclusive OR of the two operand bits, and the per-bit generate is their AND. A configuration whose width is not a whole multiple of the slice width is refused when the design is elaborated.

Top module: `hcla_adder`

## Requirements
- R1: With lookahead slice adders and a lookahead carry network, {cout, sum} equals a + b + cin for every input, with cout as bit DATA_W of the result.
- R2: With ripple slice adders and a lookahead carry network, {cout, sum} equals a + b + cin for every input.
- R3: With lookahead slice adders and a ripple carry network, {cout, sum} equals a + b + cin for every input.
- R4: With ripple slice adders and a ripple carry network, {cout, sum} equals a + b + cin for every input.
- R5: A carry input crosses every slice. Two cases show this. With a all ones, b zero and cin 1, sum is zero and cout is 1. With a and b holding complementary alternating bits and cin 1, the result is the same.
- R6: A carry generated in one slice propagates through every higher slice. With a = 0xFFFFFF80, b = 0x00000080 and cin 0 at 32 bits, sum is zero and cout is 1.
- R7: A bit that both propagates and generates gives the correct result. With a and b both all ones and cin 1, sum is all ones and cout is 1. With cin 0, sum is all ones except bit 0, which is zero, and cout is 1.
- R8: All-zero operands with cin 0 give a zero sum and a cout of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | DATA_W | First operand |
| b | input | DATA_W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | DATA_W | Low DATA_W bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
At 8 bits, with 4-bit slices, every operand pair is applied with both carry-input values to all four slice/network combinations at once. This exhaustive pass catches any wrong term in a carry formula, whichever slice position or carry index it sits in. At 32 bits, with 8-bit slices, fixed patterns are applied first, then random vectors. The fixed patterns separate three behaviours. The first is a carry that must travel the whole length from the carry input. The second is a carry born inside a low slice that must skip every slice above it. The third is bits that both generate and propagate, which shows whether the propagate was built as an inclusive OR. Random vectors then cover the mixed cases across all four builds.

// File: rtl/hcla_pkg.sv
package hcla_pkg;

  // Largest slice width and largest slice count the shared carry helper accepts.
  localparam int MAX_W = 64;

  typedef enum logic {
    ADD_LOOKAHEAD = 1'b0,
    ADD_RIPPLE    = 1'b1
  } adderKind_e;

  // Flat lookahead carry at position idx. Each carry is an OR of
  // generate-times-propagate products and never uses the carry below it.
  function automatic logic laCarry(input logic [MAX_W-1:0] prop,
                                   input logic [MAX_W-1:0] gen,
                                   input logic             carryIn,
                                   input int               idx);
    logic acc;
    logic term;
    term = carryIn;
    for (int k = 0; k < idx; k++) term = term & prop[k];
    acc = term;
    for (int j = 0; j < idx; j++) begin
      term = gen[j];
      for (int k = j + 1; k < idx; k++) term = term & prop[k];
      acc = acc | term;
    end
    return acc;
  endfunction

endpackage

// File: rtl/hcla_group.sv
module hcla_group
  import hcla_pkg::*;
#(
  parameter int         GROUP_W    = 8,
  parameter adderKind_e INNER_KIND = ADD_LOOKAHEAD
) (
  input  logic [GROUP_W-1:0] a,
  input  logic [GROUP_W-1:0] b,
  input  logic               cin,
  output logic [GROUP_W-1:0] sum,
  output logic               grpP,
  output logic               grpG
);

  logic [GROUP_W-1:0] bitP;
  logic [GROUP_W-1:0] bitG;
  logic [GROUP_W:0]   carry;
  logic [MAX_W-1:0]   pWide;
  logic [MAX_W-1:0]   gWide;

  assign bitP  = a | b;
  assign bitG  = a & b;
  assign pWide = MAX_W'(bitP);
  assign gWide = MAX_W'(bitG);

  generate
    if (INNER_KIND == ADD_LOOKAHEAD) begin : g_laInner
      for (genvar i = 0; i <= GROUP_W; i++) begin : g_bit
        assign carry[i] = laCarry(pWide, gWide, cin, i);
      end
    end else begin : g_rpInner
      always_comb begin
        logic [GROUP_W:0] chain;
        logic run;
        run = cin;
        for (int i = 0; i < GROUP_W; i++) begin
          chain[i] = run;
          run = bitG[i] | (bitP[i] & run);
        end
        chain[GROUP_W] = run;
        carry = chain;
      end
    end
  endgenerate

  assign sum  = a ^ b ^ carry[GROUP_W-1:0];
  assign grpP = &bitP;
  // The slice's own carry input is kept out of the group generate.
  assign grpG = laCarry(pWide, gWide, 1'b0, GROUP_W);

  // The slice adder's own top carry must agree with the exported summary terms.
  always_comb begin
    assert_group_carry_R6: assert (carry[GROUP_W] == (grpG | (grpP & cin)))
      else $error("slice carry disagrees with group P/G");
    assert_bit_gen_prop_R7: assert ((bitG & ~bitP) == '0)
      else $error("generate set without propagate");
  end

endmodule

// File: rtl/hcla_carry_net.sv
module hcla_carry_net
  import hcla_pkg::*;
#(
  parameter int         GROUPS   = 4,
  parameter adderKind_e NET_KIND = ADD_LOOKAHEAD
) (
  input  logic [GROUPS-1:0] grpP,
  input  logic [GROUPS-1:0] grpG,
  input  logic              cin,
  output logic [GROUPS-1:0] grpCin,
  output logic              cout
);

  logic [GROUPS:0]  carry;
  logic [MAX_W-1:0] pWide;
  logic [MAX_W-1:0] gWide;

  assign pWide = MAX_W'(grpP);
  assign gWide = MAX_W'(grpG);

  generate
    if (NET_KIND == ADD_LOOKAHEAD) begin : g_laNet
      for (genvar i = 0; i <= GROUPS; i++) begin : g_grp
        assign carry[i] = laCarry(pWide, gWide, cin, i);
      end
    end else begin : g_rpNet
      always_comb begin
        logic [GROUPS:0] chain;
        logic run;
        run = cin;
        for (int i = 0; i < GROUPS; i++) begin
          chain[i] = run;
          run = grpG[i] | (grpP[i] & run);
        end
        chain[GROUPS] = run;
        carry = chain;
      end
    end
  endgenerate

  assign grpCin = carry[GROUPS-1:0];
  assign cout   = carry[GROUPS];

  always_comb begin
    assert_net_full_prop_R5: assert (!((&grpP) && cin) || cout)
      else $error("carry input lost across fully propagating slices");
    assert_net_top_gen_R6: assert (!grpG[GROUPS-1] || cout)
      else $error("top slice generate did not reach carry-out");
  end

endmodule

// File: rtl/hcla_adder.sv
module hcla_adder
  import hcla_pkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter int         GROUP_W    = 8,
  parameter adderKind_e INNER_KIND = ADD_LOOKAHEAD,
  parameter adderKind_e NET_KIND   = ADD_LOOKAHEAD
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);

  localparam int GROUPS = DATA_W / GROUP_W;

  generate
    if ((DATA_W % GROUP_W) != 0 || GROUP_W < 1) begin : g_badWidth
      $error("DATA_W must be a whole multiple of GROUP_W");
    end
    if (GROUP_W > MAX_W || GROUPS > MAX_W) begin : g_badSize
      $error("slice width or slice count exceeds MAX_W");
    end
  endgenerate

  logic [GROUPS-1:0] grpP;
  logic [GROUPS-1:0] grpG;
  logic [GROUPS-1:0] grpCin;

  generate
    for (genvar gi = 0; gi < GROUPS; gi++) begin : g_slice
      hcla_group #(
        .GROUP_W   (GROUP_W),
        .INNER_KIND(INNER_KIND)
      ) uSlice (
        .a   (a[gi*GROUP_W +: GROUP_W]),
        .b   (b[gi*GROUP_W +: GROUP_W]),
        .cin (grpCin[gi]),
        .sum (sum[gi*GROUP_W +: GROUP_W]),
        .grpP(grpP[gi]),
        .grpG(grpG[gi])
      );
    end
  endgenerate

  hcla_carry_net #(
    .GROUPS  (GROUPS),
    .NET_KIND(NET_KIND)
  ) uNet (
    .grpP  (grpP),
    .grpG  (grpG),
    .cin   (cin),
    .grpCin(grpCin),
    .cout  (cout)
  );

endmodule

// File: tb/sim_hcla_adder.sv
`timescale 1ns/1ps
module sim_hcla_adder;
  import hcla_pkg::*;

  localparam int W8  = 8;
  localparam int W32 = 32;
  localparam int EXH = 1 << 17;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W8-1:0]  a8, b8;
  logic           c8;
  logic [W32-1:0] a32, b32;
  logic           c32;

  logic [W8-1:0]  s8 [4];
  logic           co8 [4];
  logic [W32-1:0] s32 [4];
  logic           co32 [4];

  hcla_adder #(.DATA_W(W8), .GROUP_W(4), .INNER_KIND(ADD_LOOKAHEAD), .NET_KIND(ADD_LOOKAHEAD))
    u0 (.a(a8), .b(b8), .cin(c8), .sum(s8[0]), .cout(co8[0]));
  hcla_adder #(.DATA_W(W8), .GROUP_W(4), .INNER_KIND(ADD_RIPPLE), .NET_KIND(ADD_LOOKAHEAD))
    u1 (.a(a8), .b(b8), .cin(c8), .sum(s8[1]), .cout(co8[1]));
  hcla_adder #(.DATA_W(W8), .GROUP_W(4), .INNER_KIND(ADD_LOOKAHEAD), .NET_KIND(ADD_RIPPLE))
    u2 (.a(a8), .b(b8), .cin(c8), .sum(s8[2]), .cout(co8[2]));
  hcla_adder #(.DATA_W(W8), .GROUP_W(4), .INNER_KIND(ADD_RIPPLE), .NET_KIND(ADD_RIPPLE))
    u3 (.a(a8), .b(b8), .cin(c8), .sum(s8[3]), .cout(co8[3]));

  hcla_adder #(.DATA_W(W32), .GROUP_W(8), .INNER_KIND(ADD_LOOKAHEAD), .NET_KIND(ADD_LOOKAHEAD))
    w0 (.a(a32), .b(b32), .cin(c32), .sum(s32[0]), .cout(co32[0]));
  hcla_adder #(.DATA_W(W32), .GROUP_W(8), .INNER_KIND(ADD_RIPPLE), .NET_KIND(ADD_LOOKAHEAD))
    w1 (.a(a32), .b(b32), .cin(c32), .sum(s32[1]), .cout(co32[1]));
  hcla_adder #(.DATA_W(W32), .GROUP_W(8), .INNER_KIND(ADD_LOOKAHEAD), .NET_KIND(ADD_RIPPLE))
    w2 (.a(a32), .b(b32), .cin(c32), .sum(s32[2]), .cout(co32[2]));
  hcla_adder #(.DATA_W(W32), .GROUP_W(8), .INNER_KIND(ADD_RIPPLE), .NET_KIND(ADD_RIPPLE))
    w3 (.a(a32), .b(b32), .cin(c32), .sum(s32[3]), .cout(co32[3]));

  typedef struct {
    logic [W8:0]  exp8;
    logic [W32:0] exp32;
    string        tag32;
  } sbItem_t;

  sbItem_t sbQueue[$];
  int checksRun = 0;
  int checksFailed = 0;
  logic finished = 1'b0;

  string comboTag [4] = '{"R1", "R2", "R3", "R4"};

  task automatic checkVal(input string req, input string inst,
                          input logic [W32:0] actual, input logic [W32:0] expected);
    checksRun++;
    if (actual !== expected) begin
      checksFailed++;
      $display("FAIL %s %s actual %h expected %h", req, inst, actual, expected);
    end
  endtask

  // Driver: applies one vector per cycle and records what each width must yield.
  task automatic pushVec(input logic [W8-1:0] x8, input logic [W8-1:0] y8, input logic ci8,
                         input logic [W32-1:0] x32, input logic [W32-1:0] y32, input logic ci32,
                         input string tag);
    sbItem_t item;
    @(posedge clk);
    a8 = x8; b8 = y8; c8 = ci8;
    a32 = x32; b32 = y32; c32 = ci32;
    item.exp8  = {1'b0, x8} + {1'b0, y8} + {{W8{1'b0}}, ci8};
    item.exp32 = {1'b0, x32} + {1'b0, y32} + {{W32{1'b0}}, ci32};
    item.tag32 = tag;
    sbQueue.push_back(item);
  endtask

  // Monitor: compares every build against the oldest recorded expectation.
  always @(negedge clk) begin
    if (sbQueue.size() > 0) begin
      sbItem_t got;
      got = sbQueue.pop_front();
      for (int k = 0; k < 4; k++) begin
        checkVal(comboTag[k], $sformatf("u%0d", k),
                 {{(W32-W8){1'b0}}, co8[k], s8[k]}, {{(W32-W8){1'b0}}, got.exp8});
        checkVal(got.tag32 == "" ? comboTag[k] : got.tag32, $sformatf("w%0d", k),
                 {co32[k], s32[k]}, got.exp32);
      end
    end
  end

  initial begin
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    for (int i = 0; i < EXH; i++) begin
      logic [16:0] iv;
      logic [W32-1:0] x, y;
      logic ci;
      string tag;
      iv = 17'(i);
      x = $urandom(); y = $urandom(); ci = 1'($urandom());
      tag = "";
      case (i)
        0: begin x = '0;           y = '0;           ci = 1'b0; tag = "R8"; end
        1: begin x = '1;           y = '0;           ci = 1'b1; tag = "R5"; end
        2: begin x = 32'h55555555; y = 32'hAAAAAAAA; ci = 1'b1; tag = "R5"; end
        3: begin x = 32'hFFFFFF80; y = 32'h00000080; ci = 1'b0; tag = "R6"; end
        4: begin x = '1;           y = '1;           ci = 1'b1; tag = "R7"; end
        5: begin x = '1;           y = '1;           ci = 1'b0; tag = "R7"; end
        6: begin x = 32'h00FFFFFF; y = 32'h00000001; ci = 1'b0; tag = "R6"; end
        7: begin x = '0;           y = '1;           ci = 1'b1; tag = "R5"; end
        default: ;
      endcase
      pushVec(iv[7:0], iv[15:8], iv[16], x, y, ci, tag);
    end
    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checksRun - checksFailed, checksRun);
      $finish;
    end
  end

  initial begin
    #(20.0 * 190000);
    if (!finished) begin
      finished = 1'b1;
      checksRun++;
      checksFailed++;
      $display("FAIL watchdog expired before all vectors were checked");
      $display("%0d/%0d checks passed", checksRun - checksFailed, checksRun);
      $finish;
    end
  end

endmodule